// File: doc/BRIEF.md
# Nested Trap Entry Controller

This block performs the state changes a 64-bit integer unit with register windows makes when it takes a trap. A trap request arrives as a one-cycle pulse with a 9-bit trap type, the program counter, the next program counter, the condition codes, the address space identifier, the processor state word and the current window pointer. On that clock edge the block raises the trap level and decides whether to enter the reduced-function state or to stop in a sticky error state. It also rewrites the processor state word, adjusts the window pointer and saves one entry of a small trap-state stack.

The nesting limit, the window count and the upper version bits are per-instance parameters. The block builds a read-only version word from them. A read port returns any stack entry so that the rest of the pipeline can reach the saved state. A parameter chooses whether a trap picks one of three global register sets or leaves the global selection alone. Out of reset the state word holds only the privileged bit and the boot program counter is fixed.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the trap level is 0, the state word output is 0x004 (privileged bit 2 only), the window pointer output is 0 and the error flag is low.
- R2: An accepted trap taken while the trap level is below MAXTL-1 raises the level by one on the same clock edge.
- R3: An accepted trap taken at level MAXTL-1 raises the level to MAXTL and sets the reduced-function bit (bit 5) in the output state word.
- R4: A trap taken at level MAXTL or above sets the error flag and captures the trap type and the level. It writes no stack entry and leaves the level, state word and window pointer unchanged.
- R5: While the error flag is set, trap requests have no effect until reset, and reset clears the flag.
- R6: An accepted trap writes the stack entry indexed by the new level. Its saved-state word has the condition codes in bits 39:32, the ASI in 31:24, (state word OR reduced-function bit set by this trap) AND 0xF3F in 19:8, zeros in 23:20 and 7:CWPW, and the window pointer from before the trap in the low bits.
- R7: The same entry stores the PC, the next PC and the trap type of the request.
- R8: With the global-level option absent, the new state word is PEF (bit 4) | PRIV (bit 2) | one global-select bit | the reduced-function bit if it was set on input or by this trap. The select bit is interrupt (bit 11) for type 0x060, MMU (bit 10) for types 0x008, 0x064, 0x030, 0x068 and 0x06C, and alternate (bit 0) for every other type.
- R9: A clean-window trap (type 0x024) outputs the input window pointer minus one modulo the window count. A spill trap (type AND 0x1C0 equal to 0x080) outputs the input pointer plus two modulo the window count. Any other trap passes the input pointer through.
- R10: The version word carries the upper version parameter in bits 63:16, MAXTL in bits 15:8 and the window count minus one in bits 7:0.
- R11: The boot program counter output is 0x1FFF0000020.
- R12: Without a trap request, the level, state word, window pointer and error outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | One-cycle trap request |
| trap_tt_i | input | 9 | Trap type |
| pc_i | input | 64 | Program counter at the trap |
| npc_i | input | 64 | Next program counter at the trap |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address space identifier |
| psw_i | input | 12 | Processor state word before the trap |
| cwp_i | input | CWPW | Window pointer before the trap |
| rd_idx_i | input | TLW | Stack entry to read |
| tl_o | output | TLW | Trap level |
| psw_o | output | 12 | Processor state word after the last trap |
| cwp_o | output | CWPW | Window pointer after the last trap |
| err_o | output | 1 | Sticky error state |
| err_tt_o | output | 9 | Trap type that caused the error |
| err_tl_o | output | TLW | Level at which the error occurred |
| tstate_o | output | 40 | Saved-state word of the selected entry |
| tpc_o | output | 64 | Saved PC of the selected entry |
| tnpc_o | output | 64 | Saved next PC of the selected entry |
| tt_o | output | 9 | Saved trap type of the selected entry |
| version_o | output | 64 | Read-only version word |
| boot_pc_o | output | 64 | Program counter loaded at reset |

## Verification
The properties assume that the trap request is a single-cycle pulse and that the window pointer input is always below the window count. They also assume the level can fall only through reset, because trap return lies outside the block. The stimulus drops the request for at least one cycle between traps and keeps every pointer in range. It walks the level from 0 to the limit, then issues one more trap and a further ignored trap. After that it resets and starts a second climb, with all state-word bits set on input so the save mask is exercised.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam int TT_W  = 9;
   localparam int PSW_W = 12;
   localparam int TST_W = 40;

   localparam logic [TT_W-1:0] TT_INTR_VEC   = 9'h060;
   localparam logic [TT_W-1:0] TT_IACC_FAULT = 9'h008;
   localparam logic [TT_W-1:0] TT_IACC_MISS  = 9'h064;
   localparam logic [TT_W-1:0] TT_DACC_FAULT = 9'h030;
   localparam logic [TT_W-1:0] TT_DACC_MISS  = 9'h068;
   localparam logic [TT_W-1:0] TT_DACC_PROT  = 9'h06C;
   localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
   localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
   localparam logic [TT_W-1:0] TT_CLASS_MASK = 9'h1C0;

   localparam int PSW_ALTG = 0;
   localparam int PSW_PRIV = 2;
   localparam int PSW_PEF  = 4;
   localparam int PSW_RED  = 5;
   localparam int PSW_MMUG = 10;
   localparam int PSW_INTG = 11;

   localparam logic [PSW_W-1:0] PSW_SAVE_MASK = 12'hF3F;
   localparam logic [PSW_W-1:0] PSW_RESET     = 12'h004;

   typedef enum logic [1:0] {GSEL_ALT, GSEL_INTR, GSEL_MMU} gsel_e;

   typedef struct packed {
      logic [TST_W-1:0] tstate;
      logic [63:0]      tpc;
      logic [63:0]      tnpc;
      logic [TT_W-1:0]  tt;
   } tstk_ent_t;

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl
   import trap_entry_pkg::*;
#(
   parameter int MAXTL = 5,
   parameter int TLW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [TT_W-1:0] tt,
   output logic [TLW-1:0]  tl_q,
   output logic [TLW-1:0]  tl_nxt,
   output logic            go,
   output logic            red_hit,
   output logic            err_q,
   output logic [TT_W-1:0] err_tt_q,
   output logic [TLW-1:0]  err_tl_q
);

   localparam logic [TLW-1:0] LIM  = TLW'(MAXTL);
   localparam logic [TLW-1:0] LAST = TLW'(MAXTL - 1);

   logic take;
   logic at_lim;

   assign take    = req & ~err_q;
   assign at_lim  = (tl_q >= LIM);
   assign go      = take & ~at_lim;
   assign red_hit = go & (tl_q == LAST);
   assign tl_nxt  = tl_q + TLW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl_q     <= '0;
         err_q    <= 1'b0;
         err_tt_q <= '0;
         err_tl_q <= '0;
      end else if (take) begin
         if (at_lim) begin
            err_q    <= 1'b1;
            err_tt_q <= tt;
            err_tl_q <= tl_q;
         end else begin
            tl_q <= tl_nxt;
         end
      end
   end

endmodule

// File: rtl/trap_state_upd.sv
module trap_state_upd
   import trap_entry_pkg::*;
#(
   parameter int NWIN       = 8,
   parameter int CWPW       = 3,
   parameter bit GL_PRESENT = 1'b0
) (
   input  logic [TT_W-1:0]  tt,
   input  logic [PSW_W-1:0] psw_in,
   input  logic [CWPW-1:0]  cwp_in,
   input  logic             red_hit,
   output logic [PSW_W-1:0] psw_nxt,
   output logic [PSW_W-1:0] psw_save,
   output logic [CWPW-1:0]  cwp_nxt
);

   localparam logic [CWPW:0] NWIN_W = (CWPW+1)'(NWIN);

   logic [PSW_W-1:0] red_bits;
   logic [PSW_W-1:0] base;
   logic [CWPW:0]    spill_sum;

   assign red_bits = red_hit ? (PSW_W'(1) << PSW_RED) : '0;
   assign psw_save = (psw_in | red_bits) & PSW_SAVE_MASK;
   assign base     = (PSW_W'(1) << PSW_PEF) | (PSW_W'(1) << PSW_PRIV);

   function automatic gsel_e pick_gset(input logic [TT_W-1:0] t);
      case (t)
         TT_INTR_VEC:   return GSEL_INTR;
         TT_IACC_FAULT,
         TT_IACC_MISS,
         TT_DACC_FAULT,
         TT_DACC_MISS,
         TT_DACC_PROT:  return GSEL_MMU;
         default:       return GSEL_ALT;
      endcase
   endfunction

   generate
      if (GL_PRESENT) begin : g_gl
         assign psw_nxt = psw_in | base | red_bits;
      end else begin : g_nogl
         logic [PSW_W-1:0] gbit;
         always_comb begin
            case (pick_gset(tt))
               GSEL_INTR: gbit = PSW_W'(1) << PSW_INTG;
               GSEL_MMU:  gbit = PSW_W'(1) << PSW_MMUG;
               default:   gbit = PSW_W'(1) << PSW_ALTG;
            endcase
         end
         assign psw_nxt = base | gbit | red_bits | (psw_in & (PSW_W'(1) << PSW_RED));
      end
   endgenerate

   always_comb begin
      spill_sum = {1'b0, cwp_in} + (CWPW+1)'(2);
      if (spill_sum >= NWIN_W) spill_sum = spill_sum - NWIN_W;
      if (tt == TT_CLEAN_WIN)
         cwp_nxt = (cwp_in == '0) ? CWPW'(NWIN - 1) : cwp_in - CWPW'(1);
      else if ((tt & TT_CLASS_MASK) == TT_SPILL_BASE)
         cwp_nxt = spill_sum[CWPW-1:0];
      else
         cwp_nxt = cwp_in;
   end

endmodule

// File: rtl/trap_stack.sv
module trap_stack
   import trap_entry_pkg::*;
#(
   parameter int IDXW  = 3,
   parameter int DEPTH = 8
) (
   input  logic            clk,
   input  logic            we,
   input  logic [IDXW-1:0] widx,
   input  tstk_ent_t       wdata,
   input  logic [IDXW-1:0] ridx,
   output tstk_ent_t       rdata
);

   tstk_ent_t ent [DEPTH];

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_ent
         always_ff @(posedge clk) begin
            if (we && (widx == IDXW'(k))) ent[k] <= wdata;
         end
      end
   endgenerate

   assign rdata = ent[ridx];

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_entry_pkg::*;
#(
   parameter int          MAXTL      = 5,
   parameter int          NWIN       = 8,
   parameter bit          GL_PRESENT = 1'b0,
   parameter logic [47:0] VER_HI     = 48'h003E_0010_4000,
   parameter logic [63:0] BOOT_PC    = 64'h0000_01FF_F000_0020,
   localparam int         TLW        = $clog2(MAXTL + 1),
   localparam int         CWPW       = (NWIN > 2) ? $clog2(NWIN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_req_i,
   input  logic [TT_W-1:0]  trap_tt_i,
   input  logic [63:0]      pc_i,
   input  logic [63:0]      npc_i,
   input  logic [7:0]       ccr_i,
   input  logic [7:0]       asi_i,
   input  logic [PSW_W-1:0] psw_i,
   input  logic [CWPW-1:0]  cwp_i,
   input  logic [TLW-1:0]   rd_idx_i,
   output logic [TLW-1:0]   tl_o,
   output logic [PSW_W-1:0] psw_o,
   output logic [CWPW-1:0]  cwp_o,
   output logic             err_o,
   output logic [TT_W-1:0]  err_tt_o,
   output logic [TLW-1:0]   err_tl_o,
   output logic [TST_W-1:0] tstate_o,
   output logic [63:0]      tpc_o,
   output logic [63:0]      tnpc_o,
   output logic [TT_W-1:0]  tt_o,
   output logic [63:0]      version_o,
   output logic [63:0]      boot_pc_o
);

   localparam int DEPTH = 1 << TLW;

   generate
      if (MAXTL < 2 || MAXTL > 255) begin : g_bad_maxtl
         $error("trap_entry_ctrl: MAXTL out of range");
      end
      if (NWIN < 2 || NWIN > 256) begin : g_bad_nwin
         $error("trap_entry_ctrl: NWIN out of range");
      end
   endgenerate

   logic [TLW-1:0]   tl_nxt;
   logic             go;
   logic             red_hit;
   logic [PSW_W-1:0] psw_nxt;
   logic [PSW_W-1:0] psw_save;
   logic [CWPW-1:0]  cwp_nxt;
   tstk_ent_t        wr_ent;
   tstk_ent_t        rd_ent;

   trap_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (trap_req_i),
      .tt       (trap_tt_i),
      .tl_q     (tl_o),
      .tl_nxt   (tl_nxt),
      .go       (go),
      .red_hit  (red_hit),
      .err_q    (err_o),
      .err_tt_q (err_tt_o),
      .err_tl_q (err_tl_o)
   );

   trap_state_upd #(.NWIN(NWIN), .CWPW(CWPW), .GL_PRESENT(GL_PRESENT)) u_upd (
      .tt       (trap_tt_i),
      .psw_in   (psw_i),
      .cwp_in   (cwp_i),
      .red_hit  (red_hit),
      .psw_nxt  (psw_nxt),
      .psw_save (psw_save),
      .cwp_nxt  (cwp_nxt)
   );

   assign wr_ent.tstate = {ccr_i, asi_i, 4'b0000, psw_save, 8'(cwp_i)};
   assign wr_ent.tpc    = pc_i;
   assign wr_ent.tnpc   = npc_i;
   assign wr_ent.tt     = trap_tt_i;

   trap_stack #(.IDXW(TLW), .DEPTH(DEPTH)) u_stk (
      .clk   (clk),
      .we    (go),
      .widx  (tl_nxt),
      .wdata (wr_ent),
      .ridx  (rd_idx_i),
      .rdata (rd_ent)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psw_o <= PSW_RESET;
         cwp_o <= '0;
      end else if (go) begin
         psw_o <= psw_nxt;
         cwp_o <= cwp_nxt;
      end
   end

   assign tstate_o  = rd_ent.tstate;
   assign tpc_o     = rd_ent.tpc;
   assign tnpc_o    = rd_ent.tnpc;
   assign tt_o      = rd_ent.tt;
   assign version_o = {VER_HI, 8'(MAXTL), 8'(NWIN - 1)};
   assign boot_pc_o = BOOT_PC;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
   import trap_entry_pkg::*;
#(
   parameter int MAXTL      = 5,
   parameter int TLW        = 3,
   parameter bit GL_PRESENT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trap_req_i,
   input logic [TT_W-1:0]  trap_tt_i,
   input logic [TLW-1:0]   tl_o,
   input logic [PSW_W-1:0] psw_o,
   input logic             err_o,
   input logic [TT_W-1:0]  err_tt_o
);

   assert_tl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tl_o <= TLW'(MAXTL));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && !err_o && tl_o < TLW'(MAXTL - 1)) |=> (tl_o == $past(tl_o) + TLW'(1)));

   assert_red_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && !err_o && tl_o == TLW'(MAXTL - 1)) |=> (psw_o[PSW_RED] && tl_o == TLW'(MAXTL)));

   assert_err_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && !err_o && tl_o == TLW'(MAXTL)) |=> (err_o && err_tt_o == $past(trap_tt_i)));

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (err_o && $stable(tl_o) && $stable(err_tt_o) && $stable(psw_o)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req_i |=> ($stable(tl_o) && $stable(psw_o) && $stable(err_o)));

   generate
      if (!GL_PRESENT) begin : g_gsel
         assert_one_gset_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({psw_o[PSW_INTG], psw_o[PSW_MMUG], psw_o[PSW_ALTG]}));
      end
   endgenerate

endmodule

bind trap_entry_ctrl trap_entry_chk #(.MAXTL(MAXTL), .TLW(TLW), .GL_PRESENT(GL_PRESENT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trap_req_i (trap_req_i),
   .trap_tt_i  (trap_tt_i),
   .tl_o       (tl_o),
   .psw_o      (psw_o),
   .err_o      (err_o),
   .err_tt_o   (err_tt_o)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/100ps
module sim_trap_entry_ctrl;
   import trap_entry_pkg::*;

   localparam int MAXTL = 5;
   localparam int NWIN  = 8;
   localparam int TLW   = 3;
   localparam int CWPW  = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trap_req_i = 1'b0;
   logic [TT_W-1:0]  trap_tt_i = '0;
   logic [63:0]      pc_i = '0, npc_i = '0;
   logic [7:0]       ccr_i = '0, asi_i = '0;
   logic [PSW_W-1:0] psw_i = '0;
   logic [CWPW-1:0]  cwp_i = '0;
   logic [TLW-1:0]   rd_idx_i = '0;
   logic [TLW-1:0]   tl_o, err_tl_o;
   logic [PSW_W-1:0] psw_o;
   logic [CWPW-1:0]  cwp_o;
   logic             err_o;
   logic [TT_W-1:0]  err_tt_o, tt_o;
   logic [TST_W-1:0] tstate_o;
   logic [63:0]      tpc_o, tnpc_o, version_o, boot_pc_o;

   trap_entry_ctrl #(.MAXTL(MAXTL), .NWIN(NWIN)) u0 (.*);

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      string       tag;
      logic [63:0] tl, psw, cwp, err, ett, etl, idx;
      tstk_ent_t   ent;
   } exp_t;

   exp_t q[$];

   int          m_tl, m_err;
   logic [63:0] m_psw, m_cwp, m_ett, m_etl;
   tstk_ent_t   m_stk [8];

   task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [PSW_W-1:0] gsel_bit(input logic [TT_W-1:0] t);
      if (t == 9'h060) return 12'h800;
      if (t == 9'h008 || t == 9'h064 || t == 9'h030 || t == 9'h068 || t == 9'h06C) return 12'h400;
      return 12'h001;
   endfunction

   task automatic model_reset();
      m_tl = 0; m_err = 0; m_psw = 64'h004; m_cwp = 0; m_ett = 0; m_etl = 0;
   endtask

   task automatic trap(input string tag, input logic [TT_W-1:0] tt, input logic [63:0] pc,
                       input logic [7:0] ccr, input logic [7:0] asi,
                       input logic [PSW_W-1:0] psw, input logic [CWPW-1:0] cwp);
      exp_t e;
      logic red;
      logic [PSW_W-1:0] sv;
      int c;
      if (m_err == 0) begin
         if (m_tl >= MAXTL) begin
            m_err = 1; m_ett = 64'(tt); m_etl = 64'(m_tl);
         end else begin
            red = (m_tl == MAXTL - 1);
            m_tl++;
            sv = (psw | (red ? 12'h020 : 12'h000)) & 12'hF3F;
            m_stk[m_tl].tstate = {ccr, asi, 4'h0, sv, 5'h00, cwp};
            m_stk[m_tl].tpc    = pc;
            m_stk[m_tl].tnpc   = pc + 64'd4;
            m_stk[m_tl].tt     = tt;
            m_psw = 64'(12'h014 | gsel_bit(tt) | ((red || psw[5]) ? 12'h020 : 12'h000));
            c = int'(cwp);
            if (tt == 9'h024) c = (c + NWIN - 1) % NWIN;
            else if ((tt & 9'h1C0) == 9'h080) c = (c + 2) % NWIN;
            m_cwp = 64'(c);
         end
      end
      e.tag = tag; e.tl = 64'(m_tl); e.psw = m_psw; e.cwp = m_cwp; e.err = 64'(m_err);
      e.ett = m_ett; e.etl = m_etl; e.idx = 64'(m_tl); e.ent = m_stk[m_tl];
      @(negedge clk);
      trap_req_i = 1'b1; trap_tt_i = tt; pc_i = pc; npc_i = pc + 64'd4;
      ccr_i = ccr; asi_i = asi; psw_i = psw; cwp_i = cwp;
      q.push_back(e);
      @(negedge clk);
      trap_req_i = 1'b0;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            rd_idx_i = e.idx[TLW-1:0];
            #0.5;
            cmp(e.tag, "trap level", 64'(tl_o), e.tl);
            cmp(e.tag, "state word (R8)", 64'(psw_o), e.psw);
            cmp(e.tag, "window ptr (R9)", 64'(cwp_o), e.cwp);
            cmp(e.tag, "error flag", 64'(err_o), e.err);
            if (e.err != 0) begin
               cmp(e.tag, "error type", 64'(err_tt_o), e.ett);
               cmp(e.tag, "error level", 64'(err_tl_o), e.etl);
            end
            cmp(e.tag, "saved state (R6)", 64'(tstate_o), 64'(e.ent.tstate));
            cmp(e.tag, "saved pc (R7)", tpc_o, e.ent.tpc);
            cmp(e.tag, "saved npc (R7)", tnpc_o, e.ent.tnpc);
            cmp(e.tag, "saved type (R7)", 64'(tt_o), 64'(e.ent.tt));
         end
      end
   end

   task automatic check_reset(input string tag);
      @(negedge clk);
      cmp(tag, "reset level R1", 64'(tl_o), 64'd0);
      cmp(tag, "reset state word R1", 64'(psw_o), 64'h004);
      cmp(tag, "reset window R1", 64'(cwp_o), 64'd0);
      cmp(tag, "reset error R1", 64'(err_o), 64'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [PSW_W-1:0] h_psw;
      logic [TLW-1:0]   h_tl;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset("R1");
      cmp("R10", "version word", version_o, {48'h003E_0010_4000, 8'd5, 8'd7});
      cmp("R11", "boot pc", boot_pc_o, 64'h0000_01FF_F000_0020);

      trap("R2 interrupt vector", 9'h060, 64'h1000, 8'hA5, 8'h80, 12'h004, 3'd2);
      trap("R2 data miss",        9'h068, 64'h2000, 8'h11, 8'h14, 12'h815, 3'd2);
      trap("R2 generic alt",      9'h041, 64'h3000, 8'h22, 8'h04, 12'h405, 3'd3);
      trap("R9 clean window wrap",9'h024, 64'h4000, 8'h33, 8'h88, 12'h015, 3'd0);
      trap("R3 spill at last level",9'h0A4, 64'h5000, 8'h44, 8'h10, 12'h015, 3'd7);
      trap("R4 trap at limit",    9'h031, 64'h6000, 8'h55, 8'h20, 12'h035, 3'd4);
      trap("R5 ignored in error", 9'h060, 64'h7000, 8'h66, 8'h30, 12'h004, 3'd5);
      repeat (3) @(negedge clk);

      h_psw = psw_o; h_tl = tl_o;
      repeat (4) @(negedge clk);
      cmp("R12", "idle level hold", 64'(tl_o), 64'(h_tl));
      cmp("R12", "idle state hold", 64'(psw_o), 64'(h_psw));

      do_reset();
      check_reset("R5 reset clears error");

      trap("R6 save mask all ones", 9'h008, 64'hFFFF_0000_1234_5678, 8'hFF, 8'hFF, 12'hFFF, 3'd6);
      trap("R8 data protect",       9'h06C, 64'h8000, 8'h01, 8'h02, 12'h000, 3'd1);
      trap("R8 instr miss",         9'h064, 64'h9000, 8'h03, 8'h04, 12'h000, 3'd5);
      trap("R8 data fault",         9'h030, 64'hA000, 8'h05, 8'h06, 12'h000, 3'd6);
      trap("R9 spill wrap 6",       9'h0BC, 64'hB000, 8'h07, 8'h08, 12'h000, 3'd6);
      trap("R4 second limit",       9'h1FF, 64'hC000, 8'h09, 8'h0A, 12'h000, 3'd0);
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule